// File: doc/BRIEF.md
# SRAM Access Cycle Decoder with Power-Fail Lockout

This block sits between the active-low control strobes of a byte-wide static memory and the array behind it. It takes chip-select, output-enable and write-enable samples that are already synchronous to the block clock. From them it produces the array's data-output enable and its write strobe, and it reports each finished read or write to downstream logic with a single-cycle pulse.

The block also takes comparator flags that describe the supply. While the supply sits under the write-protect threshold, every access is refused: no output drive and no write. A write that is in progress is cut off in the same cycle. Access comes back only after the supply has stayed good for a set number of clock cycles. A second output names the supply that should power the part. In 5 V mode it follows its own switch-over comparator. In 3.3 V mode it follows whichever of the write-protect threshold and the battery voltage is lower.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: `dout_en` is high in the same cycle that the samples show `ce_n`=0, `oe_n`=0 and `we_n`=1 with the block unlocked. Otherwise it is low. A read with `oe_n`=1 drives nothing.
- R2: `wr_strobe` is high in exactly those cycles in which `ce_n`=0, `we_n`=0 and the block is unlocked. The write therefore starts at the later falling strobe and stops at the earlier rising one.
- R3: Whenever `we_n`=0, `dout_en` is low, even if `oe_n`=0 and the bus was being driven in the previous cycle.
- R4: `locked` is high in any cycle where `vcc_lo_wp`=1. While `locked` is high, both `dout_en` and `wr_strobe` are low in that same cycle, including for a write already under way.
- R5: Out of reset the block is locked. It unlocks after the clock edge that ends `LOCK_HOLD` consecutive edges with `vcc_lo_wp`=0. A single edge with `vcc_lo_wp`=1 restarts the count.
- R6: A read that ends while unlocked produces `rd_done`=1 for exactly one cycle. A read ends when the samples stop showing `ce_n`=0 with `we_n`=1. The pulse appears after the clock edge at which the ending sample is taken.
- R7: A write that ends while unlocked produces `wr_done`=1 for exactly one cycle, with the same timing as R6. A write cut short by lockout produces no pulse.
- R8: With `mode_3v3`=0, `on_battery` equals `vcc_lo_so`.
- R9: With `mode_3v3`=1, `on_battery` equals `vcc_lo_wp` when `wp_below_bat`=1. Otherwise it equals `vcc_lo_bat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip-select sample, active low |
| oe_n | input | 1 | Output-enable sample, active low |
| we_n | input | 1 | Write-enable sample, active low |
| vcc_lo_wp | input | 1 | Supply is under the write-protect threshold |
| vcc_lo_bat | input | 1 | Supply is under the battery voltage |
| vcc_lo_so | input | 1 | Supply is under the 5 V switch-over level |
| mode_3v3 | input | 1 | 1 selects 3.3 V supply rules, 0 selects 5 V rules |
| wp_below_bat | input | 1 | Write-protect threshold is lower than the battery voltage |
| dout_en | output | 1 | Array data-output drive enable |
| wr_strobe | output | 1 | Array write strobe |
| locked | output | 1 | Access lockout is active |
| on_battery | output | 1 | Backup supply should be selected |
| rd_done | output | 1 | One-cycle pulse at the end of a read |
| wr_done | output | 1 | One-cycle pulse at the end of a write |

## Verification
Several properties are checked in every cycle: lockout holds both array controls low, a low write enable never leaves the bus driven, no completion pulse follows a locked cycle, a write pulse always has a strobe two cycles earlier, each pulse is lone, and the unlock counter stays in range. Other behaviours can only be shown by the bench's scenarios. These are the exact unlock edge after reset and after a glitch that restarts the count, the order of completion pulses when reads turn into writes and back, a write cut short by lockout, and the supply selection in each mode.

// File: rtl/sram_cyc_pkg.sv
// Shared types for the SRAM access cycle decoder.
package sram_cyc_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;
endpackage

// File: rtl/sram_lockout.sv
// Power-fail access lockout.
// Holds access off while the write-protect comparator reports a low supply.
// Releases only after HOLD_CYC consecutive good clock edges.
// Assumes vcc_lo_wp is already synchronous to clk. Reset leaves the block locked.
module sram_lockout #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_lo_wp,
    output logic locked
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYC - 1);

    logic             lock_q;
    logic [CNT_W-1:0] good_cnt;

    // Track good-supply edges; any low sample re-arms the lock and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b1;
            good_cnt <= '0;
        end else if (vcc_lo_wp) begin
            lock_q   <= 1'b1;
            good_cnt <= '0;
        end else if (lock_q) begin
            if (good_cnt == LAST_CNT) begin
                lock_q   <= 1'b0;
                good_cnt <= '0;
            end else begin
                good_cnt <= good_cnt + 1'b1;
            end
        end
    end

    // A low supply locks in the same cycle, with no wait for the register.
    always_comb locked = lock_q | vcc_lo_wp;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        good_cnt <= LAST_CNT); // R5
    AST_RELEASE_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(!vcc_lo_wp)); // R5
endmodule

// File: rtl/sram_supply_sel.sv
// Backup-supply selection.
// 5 V rules follow the dedicated switch-over comparator.
// 3.3 V rules switch at whichever of the write-protect threshold and the battery voltage is lower.
// Assumes all comparator flags are synchronous, level-valid samples.
module sram_supply_sel (
    input  logic mode_3v3,
    input  logic wp_below_bat,
    input  logic vcc_lo_wp,
    input  logic vcc_lo_bat,
    input  logic vcc_lo_so,
    output logic on_battery
);
    // Select the comparator that governs switch-over in the chosen supply mode.
    always_comb begin
        if (!mode_3v3)
            on_battery = vcc_lo_so;
        else if (wp_below_bat)
            on_battery = vcc_lo_wp;
        else
            on_battery = vcc_lo_bat;
    end
endmodule

// File: rtl/sram_cycle_fsm.sv
// Access cycle classifier.
// Turns the strobe samples into array controls and end-of-cycle pulses.
// Assumes the strobes are synchronous samples and that 'locked' comes from the lockout logic.
module sram_cycle_fsm
    import sram_cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic locked,
    output logic dout_en,
    output logic wr_strobe,
    output logic rd_done,
    output logic wr_done
);
    cyc_kind_t kind_now;
    cyc_kind_t kind_q;

    // Classify this cycle; lockout forces it idle, which aborts any access.
    always_comb begin
        if (locked || ce_n)
            kind_now = CYC_IDLE;
        else if (!we_n)
            kind_now = CYC_WRITE;
        else
            kind_now = CYC_READ;
    end

    // Array controls follow the current classification without delay.
    always_comb begin
        wr_strobe = (kind_now == CYC_WRITE);
        dout_en   = (kind_now == CYC_READ) && !oe_n;
    end

    // Remember the last cycle kind and pulse when an unlocked access ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CYC_IDLE;
            rd_done <= 1'b0;
            wr_done <= 1'b0;
        end else begin
            kind_q  <= kind_now;
            rd_done <= !locked && (kind_q == CYC_READ)  && (kind_now != CYC_READ);
            wr_done <= !locked && (kind_q == CYC_WRITE) && (kind_now != CYC_WRITE);
        end
    end

    AST_RD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done); // R6
    AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done); // R7
    AST_WR_DONE_HAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(wr_strobe, 2)); // R7
endmodule

// File: rtl/sram_cycle_ctrl.sv
// SRAM access cycle decoder with power-fail lockout (top).
// Combines the cycle classifier, the lockout timer and the supply selector.
// Assumes every input is already synchronous to clk.
module sram_cycle_ctrl #(
    parameter int LOCK_HOLD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic vcc_lo_wp,
    input  logic vcc_lo_bat,
    input  logic vcc_lo_so,
    input  logic mode_3v3,
    input  logic wp_below_bat,
    output logic dout_en,
    output logic wr_strobe,
    output logic locked,
    output logic on_battery,
    output logic rd_done,
    output logic wr_done
);
    sram_lockout #(.HOLD_CYC(LOCK_HOLD)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .vcc_lo_wp (vcc_lo_wp),
        .locked    (locked)
    );

    sram_cycle_fsm u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .locked    (locked),
        .dout_en   (dout_en),
        .wr_strobe (wr_strobe),
        .rd_done   (rd_done),
        .wr_done   (wr_done)
    );

    sram_supply_sel u_sup (
        .mode_3v3     (mode_3v3),
        .wp_below_bat (wp_below_bat),
        .vcc_lo_wp    (vcc_lo_wp),
        .vcc_lo_bat   (vcc_lo_bat),
        .vcc_lo_so    (vcc_lo_so),
        .on_battery   (on_battery)
    );

    AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !wr_strobe); // R4
    AST_LOCK_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !dout_en); // R4
    AST_WE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_en); // R3
    AST_NO_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !(rd_done || wr_done)); // R7
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_done, wr_done})); // R6
endmodule

// File: tb/sim_sram_cycle_ctrl.sv
// Scoreboard bench: the driver queues expected completion pulses and the monitor matches them.
module sim_sram_cycle_ctrl;
    localparam int HOLD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic vcc_lo_wp = 1'b0, vcc_lo_bat = 1'b0, vcc_lo_so = 1'b0;
    logic mode_3v3 = 1'b0, wp_below_bat = 1'b0;
    logic dout_en, wr_strobe, locked, on_battery, rd_done, wr_done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    byte exp_q[$];

    always #10 clk = ~clk;

    sram_cycle_ctrl #(.LOCK_HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vcc_lo_wp(vcc_lo_wp), .vcc_lo_bat(vcc_lo_bat), .vcc_lo_so(vcc_lo_so),
        .mode_3v3(mode_3v3), .wp_below_bat(wp_below_bat),
        .dout_en(dout_en), .wr_strobe(wr_strobe), .locked(locked),
        .on_battery(on_battery), .rd_done(rd_done), .wr_done(wr_done)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic strobes(input logic c, input logic o, input logic w);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: each completion pulse must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && (rd_done || wr_done)) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6/R7: actual pulse rd=%b wr=%b expected none", rd_done, wr_done);
            end else begin
                byte e;
                e = exp_q.pop_front();
                if ((e == "R" && !(rd_done && !wr_done)) || (e == "W" && !(wr_done && !rd_done))) begin
                    n_fail++;
                    $display("FAIL R6/R7: actual rd=%b wr=%b expected %s", rd_done, wr_done,
                             (e == "R") ? "read" : "write");
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        check(locked, 1'b1, "R5 reset locked");
        check(dout_en, 1'b0, "R1 reset dout_en");
        check(wr_strobe, 1'b0, "R2 reset wr_strobe");
        check(rd_done | wr_done, 1'b0, "R6 reset pulses");

        // R5: unlock after HOLD good edges
        @(negedge clk); rst_n = 1'b1;
        idle(HOLD - 1);
        check(locked, 1'b1, "R5 still locked");
        idle(1);
        check(locked, 1'b0, "R5 released");

        // R1 read, then R3 WE falls with OE low, turning into a write
        strobes(1'b0, 1'b0, 1'b1);
        check(dout_en, 1'b1, "R1 read drives");
        check(wr_strobe, 1'b0, "R2 no strobe in read");
        strobes(1'b0, 1'b0, 1'b0);
        exp_q.push_back("R");
        check(dout_en, 1'b0, "R3 WE releases bus");
        check(wr_strobe, 1'b1, "R2 strobe on");
        strobes(1'b1, 1'b1, 1'b0);
        exp_q.push_back("W");
        check(wr_strobe, 1'b0, "R2 CE rise ends write");
        strobes(1'b1, 1'b1, 1'b1);
        idle(2);

        // R2 CE falls last; WE rises first, leaving a read with OE high
        strobes(1'b1, 1'b1, 1'b0);
        check(wr_strobe, 1'b0, "R2 WE alone no strobe");
        strobes(1'b0, 1'b1, 1'b0);
        check(wr_strobe, 1'b1, "R2 later CE fall starts");
        idle(1);
        strobes(1'b0, 1'b1, 1'b1);
        exp_q.push_back("W");
        check(wr_strobe, 1'b0, "R2 earlier WE rise ends");
        check(dout_en, 1'b0, "R1 OE high no drive");
        idle(1);
        strobes(1'b1, 1'b1, 1'b1);
        exp_q.push_back("R");
        idle(3);

        // R4 / R7: lockout aborts write with no pulse
        strobes(1'b0, 1'b1, 1'b0);
        check(wr_strobe, 1'b1, "R2 write before lock");
        @(negedge clk); vcc_lo_wp = 1'b1; #1;
        check(locked, 1'b1, "R4 lock same cycle");
        check(wr_strobe, 1'b0, "R4 write aborted");
        strobes(1'b0, 1'b0, 1'b1);
        check(dout_en, 1'b0, "R4 read blocked");
        strobes(1'b1, 1'b1, 1'b1);
        idle(2);
        check(rd_done | wr_done, 1'b0, "R7 no pulse after abort");

        // R5: glitch restarts count
        @(negedge clk); vcc_lo_wp = 1'b0;
        idle(2);
        @(negedge clk); vcc_lo_wp = 1'b1;
        @(negedge clk); vcc_lo_wp = 1'b0;
        idle(HOLD - 1);
        check(locked, 1'b1, "R5 glitch restarted count");
        idle(1);
        check(locked, 1'b0, "R5 released after glitch");

        // R8 5 V mode
        @(negedge clk); mode_3v3 = 1'b0; vcc_lo_bat = 1'b1; #1;
        check(on_battery, 1'b0, "R8 bat flag ignored");
        @(negedge clk); vcc_lo_so = 1'b1; vcc_lo_bat = 1'b0; #1;
        check(on_battery, 1'b1, "R8 switch-over");
        // R9 3.3 V mode
        @(negedge clk); vcc_lo_so = 1'b0; mode_3v3 = 1'b1; wp_below_bat = 1'b1;
        vcc_lo_wp = 1'b1; vcc_lo_bat = 1'b0; #1;
        check(on_battery, 1'b1, "R9 wp below bat uses wp");
        @(negedge clk); vcc_lo_wp = 1'b0; vcc_lo_bat = 1'b1; #1;
        check(on_battery, 1'b0, "R9 wp below bat ignores bat");
        @(negedge clk); wp_below_bat = 1'b0; #1;
        check(on_battery, 1'b1, "R9 bat governs");
        @(negedge clk); vcc_lo_wp = 1'b1; vcc_lo_bat = 1'b0; #1;
        check(on_battery, 1'b0, "R9 wp ignored");
        @(negedge clk); vcc_lo_wp = 1'b0;

        idle(4);
        check(exp_q.size() == 0, 1'b1, "R6 R7 all pulses seen");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule